// File: doc/BRIEF.md
# Single-Precision Float/Integer Converter

This block converts between IEEE-754 single-precision values and signed 32-bit integers. A 3-bit opcode picks the operation. Four float-to-integer variants each use a fixed rounding direction. A fifth float-to-integer variant rounds with the mode held in the control register. A sixth operation converts an integer to single precision, rounding with the programmed mode. Each operation yields a result word plus an inexact flag and an invalid flag.

The programmed rounding mode arrives on a 2-bit input: 0 = to nearest (ties to even), 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. An override opcode replaces that mode for its own conversion only. The block holds no copy of the mode, so the next operation sees the programmed value again. Every accepted request produces a registered result one clock later, marked by a one-cycle strobe.

Opcode encoding: 0 = convert with the programmed mode, 1 = round to nearest-even, 2 = truncate, 3 = ceiling, 4 = floor, 5 = integer to float. Codes 6 and 7 are not operations.

Top module: `fcvt_top`

## Requirements
- R1: Opcode 0 converts a float to an integer using the rounding mode on `rnd_mode` (0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf).
- R2: Opcode 1 rounds to the nearest integer, and an exact tie goes to the even integer, whatever `rnd_mode` holds.
- R3: Opcode 2 rounds toward zero, whatever `rnd_mode` holds.
- R4: Opcode 3 rounds toward +infinity and opcode 4 rounds toward -infinity, whatever `rnd_mode` holds.
- R5: An override opcode affects only its own operation. A plain convert issued in the very next cycle rounds with the programmed mode.
- R6: Some inputs set `flag_invalid`, clear `flag_inexact` and return 0x7FFFFFFF. These are a NaN, an infinity, and a value whose magnitude is at least 2^31 other than exactly -2^31. Exactly -2^31 converts to 0x80000000 with no flag.
- R7: For float-to-integer operations, `flag_inexact` is 1 exactly when the discarded fraction bits are not all zero.
- R8: Opcode 5 converts a signed 32-bit integer to single precision with `rnd_mode`. It sets `flag_inexact` when bits are dropped and never sets `flag_invalid`.
- R9: An accepted request (`req_valid` high with opcode 0 to 5) gives `rsp_valid` high, with result and flags, in the next cycle only. Opcodes 6 and 7 give no strobe and leave result and flags unchanged.
- R10: A synchronous active-low reset clears `rsp_valid`, `result`, `flag_inexact` and `flag_invalid` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| opcode | input | 3 | Operation select (0 to 5 legal) |
| rnd_mode | input | 2 | Programmed rounding mode from the control register |
| operand | input | 32 | Float bits or signed integer, depending on opcode |
| rsp_valid | output | 1 | Result strobe, one cycle after an accepted request |
| result | output | 32 | Integer or float result |
| flag_inexact | output | 1 | Rounding discarded nonzero bits |
| flag_invalid | output | 1 | Operand not representable as a signed 32-bit integer |

## Verification
The assertions assume that `req_valid`, `opcode` and `rnd_mode` are known (not X) whenever reset is released. They also assume that an opcode of 6 or 7 is a deliberate no-op and not a glitch. The stimulus drives every input on the falling clock edge from a reset that is held for several cycles, so each value is settled and defined before it is sampled. The illegal codes are applied only in a directed check of the hold behaviour.

// File: rtl/fcvt_pkg.sv
// Package: shared encodings and format constants for the float/integer converter.
// Assumes IEEE-754 single precision and a two's-complement 32-bit integer.
package fcvt_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int MANT_W = FRAC_W + 1;
    localparam int INT_W  = 32;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int FX_W   = 2 * INT_W;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        OP_CVT   = 3'd0,
        OP_RND   = 3'd1,
        OP_TRN   = 3'd2,
        OP_CEIL  = 3'd3,
        OP_FLOOR = 3'd4,
        OP_I2F   = 3'd5
    } op_e;

    localparam logic [INT_W-1:0] INVALID_WORD = {1'b0, {(INT_W-1){1'b1}}};
endpackage

// File: rtl/fcvt_round.sv
// Module: decides whether a truncated magnitude must be incremented.
// Assumes sign-magnitude data: lsb is the kept LSB, guard the first dropped bit,
// sticky the OR of every bit below guard.
module fcvt_round
    import fcvt_pkg::*;
(
    input  rmode_e mode,
    input  logic   sign,
    input  logic   lsb,
    input  logic   guard,
    input  logic   sticky,
    output logic   inc
);
    // Increment decision per rounding direction.
    always_comb begin
        unique case (mode)
            RM_NEAR: inc = guard & (sticky | lsb);
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = ~sign & (guard | sticky);
            RM_DOWN: inc = sign & (guard | sticky);
            default: inc = 1'b0;
        endcase
    end
endmodule

// File: rtl/fcvt_f2i.sv
// Module: single-precision float to signed 32-bit integer, combinational.
// Assumes the caller supplies the effective rounding mode; subnormals are tiny values.
module fcvt_f2i
    import fcvt_pkg::*;
(
    input  logic [INT_W-1:0] fval,
    input  rmode_e           mode,
    output logic [INT_W-1:0] ival,
    output logic             inexact,
    output logic             invalid
);
    localparam int SH_W = $clog2(FX_W);

    logic                sgn;
    logic [EXP_W-1:0]    expo;
    logic [MANT_W-1:0]   mant;
    logic signed [9:0]   e_unb;
    logic [FX_W-1:0]     fx;
    logic [INT_W-1:0]    ipart;
    logic                grd, stk, is_min, bad, inc;
    logic [INT_W-1:0]    mag;

    assign sgn   = fval[INT_W-1];
    assign expo  = fval[INT_W-2 -: EXP_W];
    assign mant  = {expo != '0, fval[FRAC_W-1:0]};
    assign e_unb = $signed({2'b00, expo}) - 10'sd127;

    // Classify the operand and align it as Q32.32 fixed point.
    always_comb begin
        fx     = '0;
        ipart  = '0;
        grd    = 1'b0;
        stk    = 1'b0;
        is_min = 1'b0;
        bad    = 1'b0;
        if (expo == '1) begin
            bad = 1'b1;
        end else if (e_unb >= 10'sd31) begin
            is_min = sgn && (e_unb == 10'sd31) && (fval[FRAC_W-1:0] == '0);
            bad    = ~is_min;
        end else if (e_unb >= -10'sd1) begin
            fx    = {{(FX_W-MANT_W){1'b0}}, mant} << SH_W'(e_unb + 10'sd9);
            ipart = fx[FX_W-1:INT_W];
            grd   = fx[INT_W-1];
            stk   = |fx[INT_W-2:0];
        end else begin
            stk = |mant;
        end
    end

    fcvt_round u_rnd (
        .mode   (mode),
        .sign   (sgn),
        .lsb    (ipart[0]),
        .guard  (grd),
        .sticky (stk),
        .inc    (inc)
    );

    // Apply rounding and sign, or substitute the invalid word.
    always_comb begin
        mag     = ipart + INT_W'(inc);
        invalid = bad;
        inexact = ~bad & ~is_min & (grd | stk);
        if (bad)         ival = INVALID_WORD;
        else if (is_min) ival = {1'b1, {(INT_W-1){1'b0}}};
        else             ival = sgn ? (~mag + 1'b1) : mag;
    end
endmodule

// File: rtl/fcvt_i2f.sv
// Module: signed 32-bit integer to single-precision float, combinational.
// Assumes the caller supplies the effective rounding mode; the result never overflows.
module fcvt_i2f
    import fcvt_pkg::*;
(
    input  logic [INT_W-1:0] ival,
    input  rmode_e           mode,
    output logic [INT_W-1:0] fval,
    output logic             inexact
);
    localparam int POS_W = $clog2(INT_W);
    localparam int DROP  = INT_W - MANT_W;

    logic              sgn, inc;
    logic [INT_W-1:0]  mag, nrm;
    logic [POS_W-1:0]  lead;
    logic [MANT_W:0]   sum;
    logic [EXP_W-1:0]  expo;

    assign sgn = ival[INT_W-1];
    assign mag = sgn ? (~ival + 1'b1) : ival;

    // Locate the leading one and normalise it to the top bit.
    always_comb begin
        lead = '0;
        for (int i = 0; i < INT_W; i++) begin
            if (mag[i]) lead = POS_W'(i);
        end
        nrm = mag << (POS_W'(INT_W - 1) - lead);
    end

    fcvt_round u_rnd (
        .mode   (mode),
        .sign   (sgn),
        .lsb    (nrm[DROP]),
        .guard  (nrm[DROP-1]),
        .sticky (|nrm[DROP-2:0]),
        .inc    (inc)
    );

    // Round the mantissa, renormalise on carry, then pack the fields.
    always_comb begin
        sum     = {1'b0, nrm[INT_W-1:DROP]} + (MANT_W+1)'(inc);
        expo    = EXP_W'(BIAS) + EXP_W'(lead) + EXP_W'(sum[MANT_W]);
        inexact = |nrm[DROP-1:0];
        if (mag == '0)
            fval = '0;
        else if (sum[MANT_W])
            fval = {sgn, expo, {FRAC_W{1'b0}}};
        else
            fval = {sgn, expo, sum[FRAC_W-1:0]};
    end
endmodule

// File: rtl/fcvt_top.sv
// Module: float/integer converter top; selects the effective rounding mode per
// opcode and registers result and flags with a one-cycle strobe.
// Assumes rnd_mode is the live control-register field; no copy of it is kept.
module fcvt_top
    import fcvt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           opcode,
    input  logic [1:0]           rnd_mode,
    input  logic [INT_W-1:0]     operand,
    output logic                 rsp_valid,
    output logic [INT_W-1:0]     result,
    output logic                 flag_inexact,
    output logic                 flag_invalid
);
    rmode_e           eff_mode;
    logic             legal;
    logic [INT_W-1:0] f2i_res, i2f_res;
    logic             f2i_inx, f2i_inv, i2f_inx;

    assign legal = (opcode <= 3'(OP_I2F));

    // Effective rounding mode: overrides apply to this operation only.
    always_comb begin
        unique case (opcode)
            3'(OP_RND):   eff_mode = RM_NEAR;
            3'(OP_TRN):   eff_mode = RM_ZERO;
            3'(OP_CEIL):  eff_mode = RM_UP;
            3'(OP_FLOOR): eff_mode = RM_DOWN;
            default:      eff_mode = rmode_e'(rnd_mode);
        endcase
    end

    fcvt_f2i u_f2i (
        .fval    (operand),
        .mode    (eff_mode),
        .ival    (f2i_res),
        .inexact (f2i_inx),
        .invalid (f2i_inv)
    );

    fcvt_i2f u_i2f (
        .ival    (operand),
        .mode    (eff_mode),
        .fval    (i2f_res),
        .inexact (i2f_inx)
    );

    // Output register: capture on an accepted request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            result       <= '0;
            flag_inexact <= 1'b0;
            flag_invalid <= 1'b0;
        end else begin
            rsp_valid <= req_valid & legal;
            if (req_valid & legal) begin
                if (opcode == 3'(OP_I2F)) begin
                    result       <= i2f_res;
                    flag_inexact <= i2f_inx;
                    flag_invalid <= 1'b0;
                end else begin
                    result       <= f2i_res;
                    flag_inexact <= f2i_inx;
                    flag_invalid <= f2i_inv;
                end
            end
        end
    end

    // R9
    accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && opcode <= 3'd5) |=> rsp_valid);

    // R9
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && opcode > 3'd5) |=> (!rsp_valid && $stable(result) && $stable(flag_inexact)));

    // R6
    invalid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> (result == 32'h7FFF_FFFF && !flag_inexact));

    // R8
    i2f_never_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && opcode == 3'd5) |=> !flag_invalid);
endmodule

// File: tb/tb_fcvt_top.sv
`timescale 1ns/1ps
module tb_fcvt_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  opcode;
    logic [1:0]  rnd_mode;
    logic [31:0] operand;
    logic        rsp_valid;
    logic [31:0] result;
    logic        flag_inexact;
    logic        flag_invalid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fcvt_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
        .rnd_mode(rnd_mode), .operand(operand), .rsp_valid(rsp_valid),
        .result(result), .flag_inexact(flag_inexact), .flag_invalid(flag_invalid)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  rm;
        logic [31:0] a;
        logic [31:0] r;
        logic        x;
        logic        v;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 2'd0, 32'h40200000, 32'h00000002, 1'b1, 1'b0, 4'd1}, // R1 2.5 tie -> 2
        '{3'd0, 2'd0, 32'h40600000, 32'h00000004, 1'b1, 1'b0, 4'd1}, // R1 3.5 tie -> 4
        '{3'd0, 2'd1, 32'h402CCCCD, 32'h00000002, 1'b1, 1'b0, 4'd1}, // R1
        '{3'd0, 2'd2, 32'h402CCCCD, 32'h00000003, 1'b1, 1'b0, 4'd1}, // R1
        '{3'd0, 2'd3, 32'h402CCCCD, 32'h00000002, 1'b1, 1'b0, 4'd1}, // R1
        '{3'd0, 2'd3, 32'hC02CCCCD, 32'hFFFFFFFD, 1'b1, 1'b0, 4'd1}, // R1
        '{3'd0, 2'd2, 32'hC02CCCCD, 32'hFFFFFFFE, 1'b1, 1'b0, 4'd1}, // R1
        '{3'd1, 2'd1, 32'h40200000, 32'h00000002, 1'b1, 1'b0, 4'd2}, // R2
        '{3'd1, 2'd2, 32'hC0200000, 32'hFFFFFFFE, 1'b1, 1'b0, 4'd2}, // R2
        '{3'd1, 2'd3, 32'h3FC00000, 32'h00000002, 1'b1, 1'b0, 4'd2}, // R2
        '{3'd1, 2'd1, 32'h402CCCCD, 32'h00000003, 1'b1, 1'b0, 4'd2}, // R2
        '{3'd1, 2'd0, 32'h3F000000, 32'h00000000, 1'b1, 1'b0, 4'd2}, // R2 0.5 -> 0
        '{3'd1, 2'd2, 32'hBF000000, 32'h00000000, 1'b1, 1'b0, 4'd2}, // R2 -0.5 -> 0
        '{3'd2, 2'd2, 32'h402CCCCD, 32'h00000002, 1'b1, 1'b0, 4'd3}, // R3
        '{3'd2, 2'd0, 32'hC02CCCCD, 32'hFFFFFFFE, 1'b1, 1'b0, 4'd3}, // R3
        '{3'd3, 2'd3, 32'h402CCCCD, 32'h00000003, 1'b1, 1'b0, 4'd4}, // R4
        '{3'd3, 2'd0, 32'hC02CCCCD, 32'hFFFFFFFE, 1'b1, 1'b0, 4'd4}, // R4
        '{3'd3, 2'd1, 32'h3E800000, 32'h00000001, 1'b1, 1'b0, 4'd4}, // R4
        '{3'd4, 2'd2, 32'h402CCCCD, 32'h00000002, 1'b1, 1'b0, 4'd4}, // R4
        '{3'd4, 2'd0, 32'hBE800000, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd4}, // R4
        '{3'd4, 2'd2, 32'h80000001, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd4}, // R4 neg subnormal
        '{3'd0, 2'd0, 32'h3F800000, 32'h00000001, 1'b0, 1'b0, 4'd7}, // R7 exact
        '{3'd0, 2'd3, 32'h4E800001, 32'h40000080, 1'b0, 1'b0, 4'd7}, // R7 exact large
        '{3'd0, 2'd0, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 4'd7}, // R7 zero
        '{3'd0, 2'd0, 32'hCF000000, 32'h80000000, 1'b0, 1'b0, 4'd6}, // R6 -2^31
        '{3'd0, 2'd0, 32'h4F000000, 32'h7FFFFFFF, 1'b0, 1'b1, 4'd6}, // R6 +2^31
        '{3'd2, 2'd0, 32'h7F800000, 32'h7FFFFFFF, 1'b0, 1'b1, 4'd6}, // R6 +inf
        '{3'd0, 2'd0, 32'h7FC00000, 32'h7FFFFFFF, 1'b0, 1'b1, 4'd6}, // R6 NaN
        '{3'd4, 2'd0, 32'hFF800000, 32'h7FFFFFFF, 1'b0, 1'b1, 4'd6}, // R6 -inf
        '{3'd3, 2'd0, 32'h501502F9, 32'h7FFFFFFF, 1'b0, 1'b1, 4'd6}, // R6 1e10
        '{3'd5, 2'd0, 32'h00000001, 32'h3F800000, 1'b0, 1'b0, 4'd8}, // R8
        '{3'd5, 2'd0, 32'hFFFFFFFF, 32'hBF800000, 1'b0, 1'b0, 4'd8}, // R8
        '{3'd5, 2'd0, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 4'd8}, // R8
        '{3'd5, 2'd0, 32'h01000001, 32'h4B800000, 1'b1, 1'b0, 4'd8}, // R8 tie even
        '{3'd5, 2'd2, 32'h01000001, 32'h4B800001, 1'b1, 1'b0, 4'd8}, // R8
        '{3'd5, 2'd3, 32'hFEFFFFFF, 32'hCB800001, 1'b1, 1'b0, 4'd8}, // R8
        '{3'd5, 2'd0, 32'h7FFFFFFF, 32'h4F000000, 1'b1, 1'b0, 4'd8}, // R8 carry
        '{3'd5, 2'd1, 32'h7FFFFFFF, 32'h4EFFFFFF, 1'b1, 1'b0, 4'd8}, // R8
        '{3'd5, 2'd0, 32'h80000000, 32'hCF000000, 1'b0, 1'b0, 4'd8}, // R8
        '{3'd5, 2'd0, 32'h01000003, 32'h4B800002, 1'b1, 1'b0, 4'd8}  // R8 tie up
    };

    task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got v=%b r=%h x=%b i=%b, expected v=%b r=%h x=%b i=%b",
                     tag, act[34], act[33:2], act[1], act[0], exp[34], exp[33:2], exp[1], exp[0]);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] op, input logic [1:0] rm, input logic [31:0] a);
        req_valid = v; opcode = op; rnd_mode = rm; operand = a;
    endtask

    initial begin
        drive(1'b0, 3'd0, 2'd0, 32'h0);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R10: reset state
        check("R10", {rsp_valid, result, flag_inexact, flag_invalid}, 35'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(1'b1, VEC[i].op, VEC[i].rm, VEC[i].a);
            @(negedge clk);
            drive(1'b0, 3'd0, 2'd0, 32'h0);
            check($sformatf("R%0d vec%0d", VEC[i].req, i),
                  {rsp_valid, result, flag_inexact, flag_invalid},
                  {1'b1, VEC[i].r, VEC[i].x, VEC[i].v});
        end

        // R9: strobe lasts one cycle only
        @(negedge clk);
        check("R9 idle", {34'd0, rsp_valid}, 35'd0);

        // R5: override then plain convert, back to back
        drive(1'b1, 3'd1, 2'd1, 32'h402CCCCD);
        @(negedge clk);
        drive(1'b1, 3'd0, 2'd1, 32'h402CCCCD);
        check("R5 override", {rsp_valid, result, flag_inexact, flag_invalid}, {1'b1, 32'd3, 1'b1, 1'b0});
        @(negedge clk);
        drive(1'b0, 3'd0, 2'd0, 32'h0);
        check("R5 programmed", {rsp_valid, result, flag_inexact, flag_invalid}, {1'b1, 32'd2, 1'b1, 1'b0});

        // R9: illegal opcodes hold result and flags, no strobe
        drive(1'b1, 3'd6, 2'd0, 32'h7F800000);
        @(negedge clk);
        drive(1'b1, 3'd7, 2'd0, 32'h3F800000);
        check("R9 op6", {rsp_valid, result, flag_inexact, flag_invalid}, {1'b0, 32'd2, 1'b1, 1'b0});
        @(negedge clk);
        drive(1'b0, 3'd0, 2'd0, 32'h0);
        check("R9 op7", {rsp_valid, result, flag_inexact, flag_invalid}, {1'b0, 32'd2, 1'b1, 1'b0});

        // R10: reset mid-run clears outputs
        drive(1'b1, 3'd0, 2'd0, 32'h7FC00000);
        rst_n = 1'b0;
        @(negedge clk);
        drive(1'b0, 3'd0, 2'd0, 32'h0);
        check("R10 again", {rsp_valid, result, flag_inexact, flag_invalid}, 35'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule